// File: doc/BRIEF.md
# Write-Combining Store Buffer Array

This block gathers uncacheable processor stores aimed at a write-combining memory region and holds them in a small set of line-sized buffers, so that many narrow stores reach the memory bus as few wide writes. Each buffer covers one 64-byte aligned line. It keeps a byte-valid mask beside the data, so stores to the same line merge byte by byte. The data never passes through a cache; it goes from the buffers straight to the bus target.

A buffer leaves the array only when room is needed or on a flush. The oldest allocated buffer always goes first. A line whose 64 bytes have all been written leaves as one 8-beat burst with every byte enabled. A line with gaps leaves as separate 8-byte transfers, one for each 8-byte chunk that holds at least one written byte, each carrying that chunk's byte enables. While an eviction or a flush is running, the store port holds off new stores.

Top module: `wcb_array`

## Requirements
- R1: The array holds six line buffers of 64 bytes. An accepted store with a nonzero byte enable writes byte lane b (st_data bits 8b+7..8b, enabled by st_be[b]) into the line selected by st_addr[31:6], at byte offset 8*st_addr[5:3]+b. The bits st_addr[2:0] are ignored.
- R2: A store to a line already held merges into its buffer and causes no bus transfer. While no more than six distinct lines have been stored since the last drain, bus_valid stays low.
- R3: A store with st_be equal to zero is accepted at once and changes nothing: no buffer is allocated and no data changes.
- R4: A store with nonzero enables that misses every buffer while all six are occupied sees st_ready low. The oldest allocated buffer is evicted, and the store is then accepted into the freed buffer.
- R5: A buffer whose 64 valid bits are all set is evicted as 8 beats with bus_burst high and bus_be equal to 0xFF. The addresses run from the line base upward in steps of 8, and bus_last is high on the eighth beat only.
- R6: A buffer that is not completely written is evicted with bus_burst low. Only the 8-byte chunks that hold a valid byte are sent, in ascending address order, each with bus_be equal to that chunk's valid mask and with bus_addr[2:0] equal to zero. bus_last is high on the final chunk.
- R7: Rewriting a byte overwrites its data, and the latest value is the one evicted.
- R8: While bus_valid is high and bus_ready is low, bus_addr, bus_data, bus_be, bus_burst and bus_last hold their values into the next cycle.
- R9: A flush_req pulse drains every occupied buffer in allocation order. flush_done is then high for one cycle, in the cycle after the last handshake; with an empty array it is high in the cycle after flush_req is sampled.
- R10: st_ready is low in every cycle in which an eviction or a flush is in progress.
- R11: After reset the array is empty, bus_valid and flush_done are low, and st_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store accepted when high together with st_valid |
| st_addr | input | 32 | Store byte address |
| st_data | input | 64 | Store data, eight byte lanes |
| st_be | input | 8 | Store byte enables |
| flush_req | input | 1 | Request to drain all buffers |
| flush_done | output | 1 | One-cycle pulse when a flush has emptied the array |
| bus_valid | output | 1 | Bus write beat valid |
| bus_ready | input | 1 | Bus accepts the beat when high together with bus_valid |
| bus_addr | output | 32 | 8-byte aligned beat address |
| bus_data | output | 64 | Beat data |
| bus_be | output | 8 | Beat byte enables |
| bus_burst | output | 1 | High on every beat of a full-line burst |
| bus_last | output | 1 | Last beat of the current buffer's eviction |

## Verification
The bench builds the array with its default parameters: six buffers, 64-byte lines and 8-byte beats. Random stores are drawn from a pool of nine lines, so capacity evictions of the oldest line come up alongside merges and hits. Random enables of zero, full and sparse patterns produce full-line bursts, gapped partial evictions and ignored stores. Random bus_ready keeps the bus stalled often enough that the hold rule on the beat outputs is exercised. Directed phases cover the flush of an empty array, a single full line ahead of a partial one, byte rewrites and the seventh-line stall.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
  // Control state of the array: free to accept stores, or draining on a flush
  typedef enum logic {
    FL_OFF = 1'b0,
    FL_ON  = 1'b1
  } flush_st_e;
endpackage

// File: rtl/wcb_line.sv
module wcb_line #(
  parameter int TAG_W      = 26,
  parameter int LINE_BYTES = 64,
  parameter int BEAT_BYTES = 8,
  localparam int BEATS     = LINE_BYTES / BEAT_BYTES,
  localparam int BEAT_W    = $clog2(BEATS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_i,
  input  logic                      wr_i,
  input  logic                      clr_i,
  input  logic [TAG_W-1:0]          tag_i,
  input  logic [BEAT_W-1:0]         beat_i,
  input  logic [BEAT_BYTES*8-1:0]   data_i,
  input  logic [BEAT_BYTES-1:0]     be_i,
  output logic                      vld_o,
  output logic [TAG_W-1:0]          tag_o,
  output logic [LINE_BYTES-1:0]     mask_o,
  output logic [LINE_BYTES*8-1:0]   data_o
);
  logic                    vld_q, vld_n;
  logic [TAG_W-1:0]        tag_q;
  logic [LINE_BYTES-1:0]   mask_q, mask_n;
  logic [LINE_BYTES*8-1:0] data_q, data_n;
  logic                    data_en;

  assign data_en = alloc_i | wr_i;

  always_comb begin
    vld_n  = vld_q;
    mask_n = mask_q;
    data_n = data_q;
    if (clr_i) begin
      vld_n  = 1'b0;
      mask_n = '0;
    end
    if (alloc_i) begin
      vld_n  = 1'b1;
      mask_n = '0;
    end
    if (data_en) begin
      for (int b = 0; b < BEAT_BYTES; b++) begin
        if (be_i[b]) begin
          mask_n[int'(beat_i) * BEAT_BYTES + b] = 1'b1;
          data_n[(int'(beat_i) * BEAT_BYTES + b) * 8 +: 8] = data_i[b*8 +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      vld_q  <= vld_n;
      mask_q <= mask_n;
    end
  end

  // Payload storage carries no reset: it is only read under a valid mask
  always_ff @(posedge clk) begin
    if (data_en) data_q <= data_n;
    if (alloc_i) tag_q  <= tag_i;
  end

  assign vld_o  = vld_q;
  assign tag_o  = tag_q;
  assign mask_o = mask_q;
  assign data_o = data_q;
endmodule

// File: rtl/wcb_order.sv
module wcb_order #(
  parameter int NUM_BUF = 6,
  localparam int IDX_W  = $clog2(NUM_BUF),
  localparam int CNT_W  = $clog2(NUM_BUF + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [IDX_W-1:0] push_idx_i,
  input  logic             pop_i,
  output logic [IDX_W-1:0] head_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [IDX_W-1:0] q_q [NUM_BUF];
  logic [IDX_W-1:0] q_n [NUM_BUF];
  logic [CNT_W-1:0] cnt_q, cnt_n, wpos;

  always_comb begin
    for (int i = 0; i < NUM_BUF; i++) q_n[i] = q_q[i];
    cnt_n = cnt_q;
    if (pop_i) begin
      for (int i = 0; i < NUM_BUF - 1; i++) q_n[i] = q_q[i+1];
      cnt_n = cnt_q - CNT_W'(1);
    end
    wpos = cnt_n;
    if (push_i) begin
      for (int i = 0; i < NUM_BUF; i++) begin
        if (CNT_W'(i) == wpos) q_n[i] = push_idx_i;
      end
      cnt_n = cnt_n + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BUF; i++) q_q[i] <= '0;
      cnt_q <= '0;
    end else if (push_i || pop_i) begin
      for (int i = 0; i < NUM_BUF; i++) q_q[i] <= q_n[i];
      cnt_q <= cnt_n;
    end
  end

  assign head_o = q_q[0];
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/wcb_drain.sv
module wcb_drain #(
  parameter int LINE_BYTES = 64,
  parameter int BEAT_BYTES = 8,
  localparam int BEATS     = LINE_BYTES / BEAT_BYTES,
  localparam int BEAT_W    = $clog2(BEATS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic [LINE_BYTES-1:0] mask_i,
  input  logic                  bus_ready_i,
  output logic                  active_o,
  output logic [BEAT_W-1:0]     beat_o,
  output logic [BEAT_BYTES-1:0] be_o,
  output logic                  burst_o,
  output logic                  last_o,
  output logic                  done_o
);
  logic              active_q, active_n;
  logic              full_q, full_n;
  logic [BEAT_W-1:0] cur_q, cur_n;
  logic [BEATS-1:0]  has;
  logic [BEAT_W-1:0] sel;
  logic              found, more;

  // Pick the first chunk at or after the pointer that holds a valid byte;
  // a full line has every chunk populated, so it walks all beats in order
  always_comb begin
    sel   = '0;
    found = 1'b0;
    more  = 1'b0;
    for (int i = 0; i < BEATS; i++) has[i] = |mask_i[i*BEAT_BYTES +: BEAT_BYTES];
    for (int i = 0; i < BEATS; i++) begin
      if (!found && i >= int'(cur_q) && has[i]) begin
        sel   = BEAT_W'(i);
        found = 1'b1;
      end
    end
    for (int i = 0; i < BEATS; i++) begin
      if (i > int'(sel) && has[i]) more = 1'b1;
    end
  end

  assign active_o = active_q;
  assign beat_o   = sel;
  assign be_o     = mask_i[int'(sel)*BEAT_BYTES +: BEAT_BYTES];
  assign burst_o  = full_q;
  assign last_o   = !more;
  assign done_o   = active_q && bus_ready_i && !more;

  always_comb begin
    active_n = active_q;
    full_n   = full_q;
    cur_n    = cur_q;
    if (start_i) begin
      active_n = 1'b1;
      full_n   = &mask_i;
      cur_n    = '0;
    end else if (active_q && bus_ready_i) begin
      if (!more) active_n = 1'b0;
      else       cur_n    = sel + BEAT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      cur_q    <= '0;
    end else begin
      active_q <= active_n;
      full_q   <= full_n;
      cur_q    <= cur_n;
    end
  end
endmodule

// File: rtl/wcb_array.sv
module wcb_array
  import wcb_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_BUF    = 6,
  parameter int LINE_BYTES = 64,
  parameter int BEAT_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    st_valid,
  output logic                    st_ready,
  input  logic [ADDR_W-1:0]       st_addr,
  input  logic [BEAT_BYTES*8-1:0] st_data,
  input  logic [BEAT_BYTES-1:0]   st_be,
  input  logic                    flush_req,
  output logic                    flush_done,
  output logic                    bus_valid,
  input  logic                    bus_ready,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic [BEAT_BYTES*8-1:0] bus_data,
  output logic [BEAT_BYTES-1:0]   bus_be,
  output logic                    bus_burst,
  output logic                    bus_last
);
  localparam int BEATS  = LINE_BYTES / BEAT_BYTES;
  localparam int BEAT_W = $clog2(BEATS);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int BOFF_W = $clog2(BEAT_BYTES);
  localparam int TAG_W  = ADDR_W - OFF_W;
  localparam int IDX_W  = $clog2(NUM_BUF);
  localparam int CNT_W  = $clog2(NUM_BUF + 1);
  localparam int DATA_W = BEAT_BYTES * 8;

  logic [TAG_W-1:0]        st_tag;
  logic [BEAT_W-1:0]       st_beat;
  logic                    unused_low;
  logic [NUM_BUF-1:0]      vld, hit_vec, alloc_vec, wr_vec, clr_vec;
  logic [TAG_W-1:0]        tag_a  [NUM_BUF];
  logic [LINE_BYTES-1:0]   mask_a [NUM_BUF];
  logic [LINE_BYTES*8-1:0] data_a [NUM_BUF];
  logic                    hit, have_free, any_be, idle, accept, push, need_room, start_ev;
  logic [IDX_W-1:0]        free_idx, head_idx;
  logic [CNT_W-1:0]        cnt;
  logic                    drain_active, drain_done;
  logic [BEAT_W-1:0]       beat_sel;
  flush_st_e               fl_q, fl_n;

  assign st_tag     = st_addr[ADDR_W-1:OFF_W];
  assign st_beat    = st_addr[OFF_W-1:BOFF_W];
  assign unused_low = ^st_addr[BOFF_W-1:0];
  assign any_be     = |st_be;

  always_comb begin
    hit_vec   = '0;
    have_free = 1'b0;
    free_idx  = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      hit_vec[i] = vld[i] && (tag_a[i] == st_tag);
      if (!vld[i] && !have_free) begin
        have_free = 1'b1;
        free_idx  = IDX_W'(i);
      end
    end
  end
  assign hit = |hit_vec;

  // Stores are taken only when nothing is draining and room is known
  assign idle      = !drain_active && (fl_q == FL_OFF) && !flush_req;
  assign st_ready  = idle && (!any_be || hit || have_free);
  assign accept    = st_valid && st_ready;
  assign push      = accept && any_be && !hit;
  assign need_room = st_valid && idle && any_be && !hit && !have_free;
  assign start_ev  = !drain_active && (cnt != '0) && ((fl_q == FL_ON) || need_room);

  always_comb begin
    for (int i = 0; i < NUM_BUF; i++) begin
      wr_vec[i]    = accept && any_be && hit_vec[i];
      alloc_vec[i] = push && (free_idx == IDX_W'(i));
      clr_vec[i]   = drain_done && (head_idx == IDX_W'(i));
    end
  end

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_line
    wcb_line #(
      .TAG_W      (TAG_W),
      .LINE_BYTES (LINE_BYTES),
      .BEAT_BYTES (BEAT_BYTES)
    ) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .alloc_i (alloc_vec[g]),
      .wr_i    (wr_vec[g]),
      .clr_i   (clr_vec[g]),
      .tag_i   (st_tag),
      .beat_i  (st_beat),
      .data_i  (st_data),
      .be_i    (st_be),
      .vld_o   (vld[g]),
      .tag_o   (tag_a[g]),
      .mask_o  (mask_a[g]),
      .data_o  (data_a[g])
    );
  end

  wcb_order #(.NUM_BUF(NUM_BUF)) u_order (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push),
    .push_idx_i (free_idx),
    .pop_i      (drain_done),
    .head_o     (head_idx),
    .cnt_o      (cnt)
  );

  wcb_drain #(
    .LINE_BYTES (LINE_BYTES),
    .BEAT_BYTES (BEAT_BYTES)
  ) u_drain (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_ev),
    .mask_i      (mask_a[head_idx]),
    .bus_ready_i (bus_ready),
    .active_o    (drain_active),
    .beat_o      (beat_sel),
    .be_o        (bus_be),
    .burst_o     (bus_burst),
    .last_o      (bus_last),
    .done_o      (drain_done)
  );

  assign bus_valid = drain_active;
  assign bus_addr  = {tag_a[head_idx], beat_sel, {BOFF_W{1'b0}}};
  assign bus_data  = data_a[head_idx][int'(beat_sel)*DATA_W +: DATA_W];

  assign flush_done = (fl_q == FL_ON) && (cnt == '0) && !drain_active;

  always_comb begin
    fl_n = fl_q;
    if (fl_q == FL_ON) begin
      if (flush_done) fl_n = FL_OFF;
    end else if (flush_req) begin
      fl_n = FL_ON;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fl_q <= FL_OFF;
    else        fl_q <= fl_n;
  end
endmodule

// File: rtl/wcb_checker.sv
module wcb_checker #(
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 8,
  localparam int BOFF_W    = $clog2(BEAT_BYTES)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    st_ready,
  input logic                    flush_done,
  input logic                    bus_valid,
  input logic                    bus_ready,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [BEAT_BYTES*8-1:0] bus_data,
  input logic [BEAT_BYTES-1:0]   bus_be,
  input logic                    bus_burst,
  input logic                    bus_last
);
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_data)
      && $stable(bus_be) && $stable(bus_burst) && $stable(bus_last));

  p_burst_be_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_burst |-> bus_be == '1);

  p_burst_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && bus_burst && !bus_last |=>
      bus_valid && bus_burst && (bus_addr == $past(bus_addr) + ADDR_W'(BEAT_BYTES)));

  p_partial_be_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_burst |-> bus_be != '0);

  p_beat_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_addr[BOFF_W-1:0] == '0);

  p_stall_evict_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !st_ready);

  p_flush_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> !bus_valid && !st_ready);
endmodule

bind wcb_array wcb_checker #(
  .ADDR_W     (ADDR_W),
  .BEAT_BYTES (BEAT_BYTES)
) u_wcb_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .st_ready   (st_ready),
  .flush_done (flush_done),
  .bus_valid  (bus_valid),
  .bus_ready  (bus_ready),
  .bus_addr   (bus_addr),
  .bus_data   (bus_data),
  .bus_be     (bus_be),
  .bus_burst  (bus_burst),
  .bus_last   (bus_last)
);

// File: tb/wcb_array_bench.sv
module wcb_array_bench;
  localparam int NB = 6;
  localparam int AW = 32;
  localparam int TW = 26;
  localparam int WD_LIMIT = 150000;

  logic        clk, rst_n;
  logic        st_valid, st_ready;
  logic [31:0] st_addr;
  logic [63:0] st_data;
  logic [7:0]  st_be;
  logic        flush_req, flush_done;
  logic        bus_valid, bus_ready;
  logic [31:0] bus_addr;
  logic [63:0] bus_data;
  logic [7:0]  bus_be;
  logic        bus_burst, bus_last;

  wcb_array u_wcb_array (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .flush_req(flush_req), .flush_done(flush_done),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_be(bus_be), .bus_burst(bus_burst), .bus_last(bus_last)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int n_beats = 0;
  int n_burst = 0;
  bit rdy_always = 1'b0;

  // Reference model: lines in allocation order
  logic [TW-1:0]  m_tag  [NB];
  logic [63:0]    m_mask [NB];
  logic [511:0]   m_data [NB];
  int             m_cnt = 0;
  int             m_ptr = 0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int nxt_chunk(logic [63:0] m, int from);
    for (int k = from; k < 8; k++) if (m[k*8 +: 8] != 8'h00) return k;
    return -1;
  endfunction

  task automatic m_pop();
    for (int i = 0; i < NB - 1; i++) begin
      m_tag[i] = m_tag[i+1]; m_mask[i] = m_mask[i+1]; m_data[i] = m_data[i+1];
    end
    m_cnt--;
  endtask

  function automatic int m_find(logic [TW-1:0] t);
    for (int i = 0; i < m_cnt; i++) if (m_tag[i] == t) return i;
    return -1;
  endfunction

  task automatic m_write(logic [31:0] a, logic [63:0] d, logic [7:0] be);
    int h;
    int bt;
    if (be == 8'h00) return;
    h = m_find(a[31:6]);
    if (h < 0) begin
      chk(m_cnt < NB, "R4", "model room at allocation", 64'(m_cnt), 64'(NB - 1));
      h = m_cnt;
      m_tag[h] = a[31:6]; m_mask[h] = '0; m_data[h] = '0;
      m_cnt++;
    end
    bt = int'(a[5:3]);
    for (int b = 0; b < 8; b++) begin
      if (be[b]) begin
        m_mask[h][bt*8 + b] = 1'b1;
        m_data[h][(bt*8 + b)*8 +: 8] = d[b*8 +: 8];
      end
    end
  endtask

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WD_LIMIT) begin
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WD_LIMIT);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end

  // Bus ready driver
  initial begin
    bus_ready = 1'b0;
    forever begin
      @(posedge clk); #1;
      bus_ready = rdy_always ? 1'b1 : ($urandom_range(0, 3) != 0);
    end
  end

  // Bus monitor, sampled mid-cycle
  initial begin
    bit          hold_prev;
    logic [31:0] p_addr;
    logic [63:0] p_data;
    logic [7:0]  p_be;
    logic        p_burst, p_last;
    int          k;
    bit          full, exp_last;
    logic [7:0]  exp_be;
    logic [63:0] bm, exp_d;
    hold_prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (bus_valid) chk(!st_ready, "R10", "st_ready during eviction", 64'(st_ready), 64'd0);
        if (hold_prev) begin
          chk(bus_valid && bus_addr == p_addr && bus_data == p_data && bus_be == p_be
              && bus_burst == p_burst && bus_last == p_last, "R8", "beat held under stall",
              64'(bus_addr), 64'(p_addr));
        end
        hold_prev = bus_valid && !bus_ready;
        p_addr = bus_addr; p_data = bus_data; p_be = bus_be; p_burst = bus_burst; p_last = bus_last;
        if (bus_valid && bus_ready) begin
          n_beats++;
          if (bus_burst) n_burst++;
          if (m_cnt == 0) begin
            chk(1'b0, "R2", "unexpected bus beat", 64'(bus_addr), 64'd0);
          end else begin
            full = (m_mask[0] == '1);
            k = nxt_chunk(m_mask[0], m_ptr);
            if (k < 0) k = 0;
            exp_be = m_mask[0][k*8 +: 8];
            exp_last = (nxt_chunk(m_mask[0], k + 1) < 0);
            for (int b = 0; b < 8; b++) bm[b*8 +: 8] = {8{exp_be[b]}};
            exp_d = m_data[0][k*64 +: 64] & bm;
            chk(bus_addr == {m_tag[0], 3'(k), 3'b000}, full ? "R5" : "R6", "beat address",
                64'(bus_addr), 64'({m_tag[0], 3'(k), 3'b000}));
            chk(bus_be == exp_be, full ? "R5" : "R6", "beat byte enables", 64'(bus_be), 64'(exp_be));
            chk(bus_burst == full, full ? "R5" : "R6", "burst flag", 64'(bus_burst), 64'(full));
            chk(bus_last == exp_last, full ? "R5" : "R6", "last flag", 64'(bus_last), 64'(exp_last));
            chk((bus_data & bm) == exp_d, "R7", "beat data R6", bus_data & bm, exp_d);
            m_ptr = k + 1;
            if (exp_last) begin
              m_pop();
              m_ptr = 0;
            end
          end
        end
      end else begin
        hold_prev = 1'b0;
      end
    end
  end

  task automatic do_store(logic [31:0] a, logic [63:0] d, logic [7:0] be, string req);
    int  stall;
    bit  exp_stall;
    exp_stall = (be != 8'h00) && (m_find(a[31:6]) < 0) && (m_cnt == NB);
    @(posedge clk); #1;
    st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
    stall = 0;
    @(negedge clk);
    while (!st_ready && stall < 3000) begin
      stall++;
      @(negedge clk);
    end
    chk(st_ready, req, "store accepted", 64'(st_ready), 64'd1);
    chk((stall > 0) == exp_stall, exp_stall ? "R4" : req, "store stall",
        64'(stall), 64'(exp_stall));
    m_write(a, d, be);
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic do_flush(bit empty_case);
    int waited;
    @(posedge clk); #1; flush_req = 1'b1;
    @(posedge clk); #1; flush_req = 1'b0;
    waited = 0;
    @(negedge clk);
    while (!flush_done && waited < 5000) begin
      waited++;
      @(negedge clk);
    end
    chk(flush_done, "R9", "flush_done seen", 64'(flush_done), 64'd1);
    chk(m_cnt == 0, "R9", "array drained", 64'(m_cnt), 64'd0);
    if (empty_case) chk(waited == 0, "R9", "empty flush latency", 64'(waited), 64'd0);
    @(negedge clk);
    chk(!flush_done, "R9", "flush_done one cycle", 64'(flush_done), 64'd0);
  endtask

  function automatic logic [31:0] line_a(int ln, int bt, int low);
    return 32'h1000_0000 + 32'(ln << 6) + 32'(bt << 3) + 32'(low);
  endfunction

  initial begin
    int b0, c0;
    void'($urandom(32'd1234));
    rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_data = '0; st_be = '0; flush_req = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_valid, "R11", "bus_valid after reset", 64'(bus_valid), 64'd0);
    chk(st_ready, "R11", "st_ready after reset", 64'(st_ready), 64'd1);
    chk(!flush_done, "R11", "flush_done after reset", 64'(flush_done), 64'd0);

    // R1, R2, R7: merges into one line, low address bits ignored, byte rewrite
    b0 = n_beats;
    do_store(line_a(3, 2, 5), 64'h1122_3344_5566_7788, 8'h0F, "R1");
    do_store(line_a(3, 2, 0), 64'hAABB_CCDD_EEFF_0011, 8'hF0, "R2");
    do_store(line_a(3, 5, 7), 64'h0000_0000_00C3_0000, 8'h04, "R2");
    do_store(line_a(3, 2, 1), 64'h0000_0000_0000_005A, 8'h01, "R7");
    chk(n_beats == b0, "R2", "no traffic on merges", 64'(n_beats - b0), 64'd0);
    // R3: zero-enable store to a new line is ignored
    do_store(line_a(7, 0, 0), 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, "R3");
    chk(m_cnt == 1, "R3", "model lines after ignored store", 64'(m_cnt), 64'd1);
    do_flush(1'b0);
    chk(n_beats - b0 == 2, "R6", "partial chunk count", 64'(n_beats - b0), 64'd2);

    // R9: flush of an empty array
    do_flush(1'b1);

    // R5: one full line ahead of a partial line
    b0 = n_beats; c0 = n_burst;
    for (int i = 0; i < 8; i++) do_store(line_a(10, i, 0), {$urandom, $urandom}, 8'hFF, "R5");
    do_store(line_a(11, 6, 0), {$urandom, $urandom}, 8'h81, "R6");
    chk(n_beats == b0, "R2", "no traffic before flush", 64'(n_beats - b0), 64'd0);
    do_flush(1'b0);
    chk(n_burst - c0 == 8, "R5", "burst beat count", 64'(n_burst - c0), 64'd8);
    chk(n_beats - b0 == 9, "R6", "total beats", 64'(n_beats - b0), 64'd9);

    // R4: seventh distinct line forces out the oldest; R3 zero enable still flows
    b0 = n_beats;
    for (int i = 0; i < NB; i++) do_store(line_a(20 + i, i % 8, 0), {$urandom, $urandom}, 8'h10, "R1");
    chk(n_beats == b0, "R2", "six lines held without traffic", 64'(n_beats - b0), 64'd0);
    do_store(line_a(40, 0, 0), 64'h0, 8'h00, "R3");
    chk(n_beats == b0, "R3", "zero-enable store no eviction", 64'(n_beats - b0), 64'd0);
    do_store(line_a(30, 1, 0), {$urandom, $urandom}, 8'h3C, "R4");
    chk(n_beats - b0 == 1, "R4", "one eviction for seventh line", 64'(n_beats - b0), 64'd1);
    do_flush(1'b0);

    // Random traffic over nine lines
    for (int n = 0; n < 600; n++) begin
      int r;
      logic [7:0] be;
      r = $urandom_range(0, 9);
      if (r == 0)      be = 8'h00;
      else if (r < 4)  be = 8'hFF;
      else             be = 8'($urandom_range(1, 255));
      do_store(line_a(50 + $urandom_range(0, 8), $urandom_range(0, 7), $urandom_range(0, 7)),
               {$urandom, $urandom}, be, "R2");
      if ($urandom_range(0, 59) == 0) do_flush(1'b0);
    end
    rdy_always = 1'b1;
    do_flush(1'b0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule